// File: doc/BRIEF.md
# Dual Range Bus Timeout Timer

This block is a watchdog for bus cycles. It runs only while the node acts as system controller of the interconnect. It starts counting when a bus cycle begins. If the cycle has not ended once a programmable limit has elapsed, it raises a single-clock timeout pulse, and the surrounding bus logic turns that pulse into an error termination.

The limit comes from two inputs. A range bit picks microsecond units (short range) or millisecond units (long range). A static two-bit strap picks 100, 200, 300 or 400 of those units. A prescaler derives the units from the clock, using `CLK_PER_US` clocks per microsecond and `US_PER_MS` microseconds per millisecond. The range bit and the strap are captured when a cycle starts, so changing them while a cycle is open has no effect on that cycle.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: Synchronous active-high reset drives `timeout_pulse` low and abandons any open cycle, so no pulse follows until a new start is accepted.
- R2: With `long_range`=0 captured at the start, the pulse rises exactly (strap+1)*100*CLK_PER_US clock edges after the edge that sampled `cyc_start`.
- R3: With `long_range`=1 captured at the start, the pulse rises exactly (strap+1)*100*US_PER_MS*CLK_PER_US clock edges after the start edge.
- R4: Strap encoding: 2'b00 selects 100 units, 2'b01 selects 200, 2'b10 selects 300 and 2'b11 selects 400.
- R5: `long_range` and `strap` are sampled only on the start edge. Changes made during an open cycle do not alter that cycle's limit.
- R6: A `cyc_end` sampled before or on the edge where the limit is reached closes the cycle, and no pulse is produced for it.
- R7: An overrunning cycle produces exactly one pulse, one clock wide. No further pulse follows until another start.
- R8: While `sys_ctrl` is low, starts are ignored and no pulse is produced. Dropping `sys_ctrl` during an open cycle cancels that cycle.
- R9: A `cyc_start` during an open cycle restarts the count from that edge, and it has priority over a `cyc_end` sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| sys_ctrl | input | 1 | High when this node is the system controller |
| long_range | input | 1 | 0 selects microsecond units, 1 selects millisecond units |
| strap | input | STRAP_W | Static code selecting the multiple of 100 units |
| cyc_start | input | 1 | Bus cycle begins (sampled on the clock edge) |
| cyc_end | input | 1 | Bus cycle completes (sampled on the clock edge) |
| timeout_pulse | output | 1 | One-clock pulse when the open cycle overruns its limit |

## Verification
The hardest case to reach is a cycle end that lands on the same edge as the timeout. Hitting it needs exact edge counting from the start edge through both prescaler stages. The bench builds a small configuration (2 clocks per microsecond, 3 microseconds per millisecond) so that every range and strap combination can be swept in full. It computes each limit arithmetically, places `cyc_end` precisely on the edge where the limit is reached, and checks that the pulse is suppressed. Mid-cycle changes to range and strap, restarts and controller-role loss are driven at fixed offsets from the start edge.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  typedef enum logic {UNIT_US = 1'b0, UNIT_MS = 1'b1} unit_e;

  function automatic int calc_units(input int code, input int step);
    return (code + 1) * step;
  endfunction
endpackage

// File: rtl/bcw_tick_gen.sv
module bcw_tick_gen #(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic us_tick,
  output logic ms_tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(CLK_PER_US - 1);
  localparam logic [UW-1:0] U_LAST = UW'(US_PER_MS - 1);

  logic [CW-1:0] clk_cnt;
  logic [UW-1:0] us_cnt;

  assign us_tick = run && (clk_cnt == C_LAST);
  assign ms_tick = us_tick && (us_cnt == U_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      clk_cnt <= '0;
      us_cnt  <= '0;
    end else if (run) begin
      clk_cnt <= (clk_cnt == C_LAST) ? '0 : clk_cnt + 1'b1;
      if (us_tick)
        us_cnt <= (us_cnt == U_LAST) ? '0 : us_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bcw_unit_counter.sv
module bcw_unit_counter #(
  parameter int LIM_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             hit
);
  logic [LIM_W-1:0] units;

  assign hit = tick && (units == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr)
      units <= '0;
    else if (tick)
      units <= units + 1'b1;
  end
endmodule

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog
  import bcw_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000,
  parameter int STEP_UNITS = 100,
  parameter int STRAP_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sys_ctrl,
  input  logic               long_range,
  input  logic [STRAP_W-1:0] strap,
  input  logic               cyc_start,
  input  logic               cyc_end,
  output logic               timeout_pulse
);
  localparam int MAX_UNITS = STEP_UNITS * (2 ** STRAP_W);
  localparam int LIM_W     = $clog2(MAX_UNITS + 1);

  logic             active;
  unit_e            unit_q;
  logic [LIM_W-1:0] limit_q;
  logic             start_ok;
  logic             us_tick, ms_tick, unit_tick, hit;

  assign start_ok  = sys_ctrl && cyc_start;
  assign unit_tick = (unit_q == UNIT_MS) ? ms_tick : us_tick;

  bcw_tick_gen #(
    .CLK_PER_US(CLK_PER_US),
    .US_PER_MS (US_PER_MS)
  ) u_ticks (
    .clk    (clk),
    .rst    (rst),
    .clr    (start_ok),
    .run    (active),
    .us_tick(us_tick),
    .ms_tick(ms_tick)
  );

  bcw_unit_counter #(
    .LIM_W(LIM_W)
  ) u_units (
    .clk  (clk),
    .rst  (rst),
    .clr  (start_ok),
    .tick (unit_tick),
    .limit(limit_q),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active        <= 1'b0;
      unit_q        <= UNIT_US;
      limit_q       <= '0;
      timeout_pulse <= 1'b0;
    end else begin
      timeout_pulse <= 1'b0;
      if (!sys_ctrl) begin
        active <= 1'b0;
      end else if (cyc_start) begin
        active  <= 1'b1;
        unit_q  <= long_range ? UNIT_MS : UNIT_US;
        limit_q <= LIM_W'(calc_units(int'(strap), STEP_UNITS));
      end else if (cyc_end) begin
        active <= 1'b0;
      end else if (active && hit) begin
        active        <= 1'b0;
        timeout_pulse <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcw_checker.sv
module bcw_checker (
  input logic clk,
  input logic rst,
  input logic sys_ctrl,
  input logic cyc_start,
  input logic cyc_end,
  input logic timeout_pulse
);
  // R1: reset leaves the output low on the next cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !timeout_pulse);

  // R7: pulse is one clock wide
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |=> !timeout_pulse);

  // R8: no pulse after an edge without controller role
  a_r8_no_ctrl_quiet: assert property (@(posedge clk) disable iff (rst)
    !sys_ctrl |=> !timeout_pulse);

  // R6: a sampled cycle end suppresses the pulse
  a_r6_end_suppresses: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !cyc_start) |=> !timeout_pulse);

  // R9: a restart never fires on the following cycle
  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !timeout_pulse);
endmodule

bind bus_cycle_watchdog bcw_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .sys_ctrl     (sys_ctrl),
  .cyc_start    (cyc_start),
  .cyc_end      (cyc_end),
  .timeout_pulse(timeout_pulse)
);

// File: tb/bus_cycle_watchdog_tb.sv
module bus_cycle_watchdog_tb;
  localparam int P = 2;
  localparam int M = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sys_ctrl = 1'b1;
  logic       long_range = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       cyc_start = 1'b0;
  logic       cyc_end = 1'b0;
  logic       timeout_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_cycle_watchdog #(.CLK_PER_US(P), .US_PER_MS(M)) u_dut (
    .clk(clk), .rst(rst), .sys_ctrl(sys_ctrl), .long_range(long_range),
    .strap(strap), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .timeout_pulse(timeout_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #2;
  endtask

  task automatic start_cycle();
    cyc_start = 1'b1;
    edge_step();
    cyc_start = 1'b0;
  endtask

  task automatic watch(input int maxn, output int first, output int count);
    first = 0;
    count = 0;
    for (int n = 1; n <= maxn; n++) begin
      edge_step();
      if (timeout_pulse) begin
        count++;
        if (first == 0) first = n;
      end
    end
  endtask

  function automatic int expect_edges(input bit lr, input int code);
    return (code + 1) * 100 * P * (lr ? M : 1);
  endfunction

  initial begin
    int first, count, t;
    repeat (3) edge_step();
    check(timeout_pulse == 1'b0, "R1 reset state", timeout_pulse, 0);
    rst = 1'b0;
    edge_step();

    // R2 R3 R4: sweep both ranges and every strap code
    for (int lr = 0; lr < 2; lr++) begin
      for (int code = 0; code < 4; code++) begin
        long_range = lr[0];
        strap = code[1:0];
        t = expect_edges(lr[0], code);
        start_cycle();
        watch(2 * t, first, count);
        check(first == t, lr ? "R3 long limit (R4 code)" : "R2 short limit (R4 code)", first, t);
        check(count == 1, "R7 single pulse", count, 1);
      end
    end

    // R5: change range and strap right after the start edge
    long_range = 1'b0; strap = 2'b00;
    start_cycle();
    long_range = 1'b1; strap = 2'b11;
    watch(400, first, count);
    check(first == 200, "R5 mid-cycle change ignored", first, 200);

    // R6: end sampled on exactly the timeout edge
    long_range = 1'b0; strap = 2'b01;
    start_cycle();
    repeat (399) edge_step();
    cyc_end = 1'b1;
    edge_step();
    cyc_end = 1'b0;
    check(timeout_pulse == 1'b0, "R6 end on limit edge", timeout_pulse, 0);
    watch(800, first, count);
    check(count == 0, "R6 no later pulse", count, 0);

    // R6: early end
    strap = 2'b00;
    start_cycle();
    repeat (50) edge_step();
    cyc_end = 1'b1; edge_step(); cyc_end = 1'b0;
    watch(400, first, count);
    check(count == 0, "R6 early end", count, 0);

    // R9: restart during an open cycle
    start_cycle();
    watch(150, first, count);
    check(count == 0, "R9 before restart", count, 0);
    start_cycle();
    watch(400, first, count);
    check(first == 200, "R9 restart timing", first, 200);

    // R9: start and end on the same edge -> start wins
    cyc_end = 1'b1;
    start_cycle();
    cyc_end = 1'b0;
    watch(400, first, count);
    check(first == 200, "R9 start over end", first, 200);

    // R8: starts ignored without controller role
    sys_ctrl = 1'b0;
    start_cycle();
    watch(500, first, count);
    check(count == 0, "R8 start ignored", count, 0);
    // R8: role lost mid-cycle
    sys_ctrl = 1'b1;
    start_cycle();
    repeat (100) edge_step();
    sys_ctrl = 1'b0; edge_step(); sys_ctrl = 1'b1;
    watch(400, first, count);
    check(count == 0, "R8 role lost cancels", count, 0);

    // R1: reset mid-cycle abandons it
    start_cycle();
    repeat (60) edge_step();
    rst = 1'b1; edge_step(); rst = 1'b0;
    watch(400, first, count);
    check(count == 0, "R1 reset cancels cycle", count, 0);

    // R7: short range again, pulse width one clock
    start_cycle();
    watch(199, first, count);
    edge_step();
    check(timeout_pulse == 1'b1, "R7 pulse present", timeout_pulse, 1);
    edge_step();
    check(timeout_pulse == 1'b0, "R7 pulse width", timeout_pulse, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule